// File: doc/BRIEF.md
# Supply-Good Reset Sequencer

This block converts the digital output of an external supply comparator into a clean, active-low system reset. The comparator level arrives asynchronously. It passes through a synchronizer and then a glitch filter, so that only a low level that lasts long enough counts as a real supply drop. After the level has been good, the block counts a fixed number of timebase ticks, one watchdog period, before it releases reset. On the release edge it emits a one-cycle strobe that starts the downstream watchdog's first window.

A qualified supply drop pulls reset low at once, whatever the timer or the watchdog is doing. A drop that occurs while the release delay is counting throws away the ticks counted so far, so the delay begins again from zero once the level is good again. This stops reset from chattering on a marginal supply. Watchdog clear pulses pass through the block and are blocked while reset is held, so they cannot act before the sequence has completed. There is no data path, so every pin is a plain control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `supply_reset_sequencer`

## Requirements
- R1: While the filtered level reports below-threshold (including straight after hardware reset), `sys_rst_n` stays 0 and `seq_done` stays 0, and ticks have no effect.
- R2: After the filtered level becomes good, `sys_rst_n` rises on the clock edge that samples the TWD_TICKS-th `tick` seen while good, and not before.
- R3: `seq_done` is high for exactly one cycle, in the same cycle in which `sys_rst_n` first reads 1, and at no other time.
- R4: A low on `lvl_above` lasting fewer than FILT_CYC consecutive synchronized samples is ignored: reset stays released, and a release delay in progress continues without restarting.
- R5: A low lasting FILT_CYC or more samples forces `sys_rst_n` to 0 on clock edge FILT_CYC+3, counted from the first edge that sees the input low (2 synchronizer stages, the filter, then the output register).
- R6: A qualified drop during the release delay discards the ticks already counted, and the next release needs a full TWD_TICKS ticks after the level recovers.
- R7: `clr_out` equals `clr_in` while `sys_rst_n` is 1 and is 0 while it is 0.
- R8: `rst_n` low drives `sys_rst_n` and `seq_done` to 0 asynchronously and returns the block to the held state, which needs a full release delay before reset is released again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| tick | input | 1 | One-cycle timebase tick for the release delay |
| lvl_above | input | 1 | Asynchronous comparator level, 1 = supply above threshold |
| clr_in | input | 1 | Watchdog clear request from software |
| sys_rst_n | output | 1 | Active-low system reset |
| seq_done | output | 1 | One-cycle strobe when reset is released |
| clr_out | output | 1 | Clear request forwarded to the watchdog, gated by reset |

## Verification
A table of dip lengths is applied to a released block: dips of 1, 3 and FILT_CYC-1 cycles, which must be filtered out, and dips of FILT_CYC, FILT_CYC+3 and 30 cycles, which must force reset. Each case then checks whether a new release delay is needed, and this tells the filter's qualification boundary apart from an off-by-one. Directed sequences hold the level low while ticks arrive, release after exactly TWD_TICKS ticks (this separates a counter that ends one tick early from one that ends one tick late), and interrupt the delay both with a qualified drop and with a short dip. The difference between restarting the delay and continuing it shows at the exact tick of release. Other sequences gate clear pulses and apply a hardware reset while reset is released.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } srs_state_e;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srs_dip_filter.sv
module srs_dip_filter #(
  parameter int FILT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic qual_low
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] low_cnt;

  // Count consecutive low samples; qualify on the FILT_CYC-th one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      qual_low <= 1'b1;
    end else if (lvl) begin
      low_cnt  <= '0;
      qual_low <= 1'b0;
    end else if (!qual_low) begin
      if (low_cnt == LAST) qual_low <= 1'b1;
      else                 low_cnt  <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srs_release_timer.sv
module srs_release_timer
  import srs_pkg::*;
#(
  parameter int TWD_TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic qual_low,
  output logic sys_rst_n,
  output logic seq_done
);
  localparam int TW = $clog2(TWD_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(TWD_TICKS - 1);

  srs_state_e    st, st_n;
  logic [TW-1:0] tcnt, tcnt_n;
  logic          done_n;

  always_comb begin
    st_n   = st;
    tcnt_n = tcnt;
    done_n = 1'b0;
    case (st)
      ST_HOLD: begin
        if (qual_low) begin
          tcnt_n = '0;
        end else if (tick) begin
          if (tcnt == LAST) begin
            st_n   = ST_RUN;
            tcnt_n = '0;
            done_n = 1'b1;
          end else begin
            tcnt_n = tcnt + 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (qual_low) begin
          st_n   = ST_HOLD;
          tcnt_n = '0;
        end
      end
      default: begin
        st_n   = ST_HOLD;
        tcnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HOLD;
      tcnt      <= '0;
      sys_rst_n <= 1'b0;
      seq_done  <= 1'b0;
    end else begin
      st        <= st_n;
      tcnt      <= tcnt_n;
      sys_rst_n <= (st_n == ST_RUN);
      seq_done  <= done_n;
    end
  end
endmodule

// File: rtl/supply_reset_sequencer.sv
module supply_reset_sequencer #(
  parameter int FILT_CYC    = 1000,
  parameter int TWD_TICKS   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic lvl_above,
  input  logic clr_in,
  output logic sys_rst_n,
  output logic seq_done,
  output logic clr_out
);
  logic lvl_sync;
  logic qual_low;

  srs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (lvl_above),
    .q     (lvl_sync)
  );

  srs_dip_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl      (lvl_sync),
    .qual_low (qual_low)
  );

  srs_release_timer #(.TWD_TICKS(TWD_TICKS)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .qual_low  (qual_low),
    .sys_rst_n (sys_rst_n),
    .seq_done  (seq_done)
  );

  // Clear requests reach the watchdog only once reset is released.
  assign clr_out = clr_in & sys_rst_n;
endmodule

// File: rtl/supply_reset_sequencer_chk.sv
module supply_reset_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic qual_low,
  input logic clr_in,
  input logic sys_rst_n,
  input logic seq_done,
  input logic clr_out
);
  // R3: strobe only on the release edge
  a_r3_done_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> (sys_rst_n && !$past(sys_rst_n)));

  // R3: every release carries the strobe
  a_r3_rise_has_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> seq_done);

  // R2: release happens only on a sampled tick
  a_r2_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(tick));

  // R5: a qualified drop forces reset on the next edge
  a_r5_drop_forces: assert property (@(posedge clk) disable iff (!rst_n)
    qual_low |=> !sys_rst_n);

  // R1: no strobe while the level is qualified low
  a_r1_no_done_low: assert property (@(posedge clk) disable iff (!rst_n)
    qual_low |-> !seq_done);

  // R7: clears blocked while reset is held
  a_r7_clr_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst_n |-> !clr_out);

  // R7: clears forwarded once released
  a_r7_clr_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_n && clr_in) |-> clr_out);

  // R8: hardware reset holds both outputs low
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r8_hw_reset: assert (!sys_rst_n && !seq_done);
    end
  end
endmodule

bind supply_reset_sequencer supply_reset_sequencer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .qual_low  (qual_low),
  .clr_in    (clr_in),
  .sys_rst_n (sys_rst_n),
  .seq_done  (seq_done),
  .clr_out   (clr_out)
);

// File: tb/supply_reset_sequencer_test.sv
module supply_reset_sequencer_test;
  localparam int F   = 8;
  localparam int TWD = 10;
  localparam int NV  = 6;
  localparam int unsigned DIP_LEN [NV] = '{1, 3, F-1, F, F+3, 30};
  localparam bit          EXP_DROP [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic tick = 1'b0;
  logic lvl_above = 1'b0;
  logic clr_in = 1'b0;
  logic sys_rst_n, seq_done, clr_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  supply_reset_sequencer #(.FILT_CYC(F), .TWD_TICKS(TWD), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lvl_above(lvl_above),
    .clr_in(clr_in), .sys_rst_n(sys_rst_n), .seq_done(seq_done), .clr_out(clr_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic release_seq();
    lvl_above = 1'b1;
    cyc(5);
    ticks(TWD);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    cyc(3);
    chk("R8 reset sys_rst_n", sys_rst_n, 1'b0);
    chk("R8 reset seq_done", seq_done, 1'b0);
    rst_n = 1'b1;

    // R1: level low, ticks ignored
    ticks(20);
    chk("R1 held while low", sys_rst_n, 1'b0);
    chk("R1 no strobe while low", seq_done, 1'b0);
    clr_in = 1'b1; cyc(1);
    chk("R7 clear blocked in reset", clr_out, 1'b0);
    clr_in = 1'b0;

    // R2/R3: exact release tick and strobe
    lvl_above = 1'b1;
    cyc(5);
    ticks(TWD - 1);
    chk("R2 not released one tick early", sys_rst_n, 1'b0);
    tick = 1'b1; @(negedge clk);
    chk("R2 released on last tick", sys_rst_n, 1'b1);
    chk("R3 strobe with release", seq_done, 1'b1);
    tick = 1'b0; @(negedge clk);
    chk("R3 strobe one cycle", seq_done, 1'b0);
    chk("R2 stays released", sys_rst_n, 1'b1);
    clr_in = 1'b1; cyc(1);
    chk("R7 clear forwarded", clr_out, 1'b1);
    clr_in = 1'b0; cyc(1);
    chk("R7 clear follows input", clr_out, 1'b0);

    // R5: exact force latency
    lvl_above = 1'b0;
    cyc(F + 2);
    chk("R5 still released before edge F+3", sys_rst_n, 1'b1);
    cyc(1);
    chk("R5 forced on edge F+3", sys_rst_n, 1'b0);
    release_seq();
    chk("R2 re-release", sys_rst_n, 1'b1);

    // R4/R5: dip-length table
    for (int i = 0; i < NV; i++) begin
      lvl_above = 1'b0;
      cyc(int'(DIP_LEN[i]));
      lvl_above = 1'b1;
      cyc(F + 6);
      if (EXP_DROP[i]) begin
        chk("R5 qualified dip forces reset", sys_rst_n, 1'b0);
        ticks(TWD);
        chk("R2 release after dip", sys_rst_n, 1'b1);
      end else begin
        chk("R4 short dip ignored", sys_rst_n, 1'b1);
      end
    end

    // R6: qualified drop restarts the delay
    rst_n = 1'b0; cyc(1); rst_n = 1'b1;
    cyc(5);
    ticks(5);
    lvl_above = 1'b0; cyc(F + 2);
    lvl_above = 1'b1; cyc(5);
    ticks(TWD - 1);
    chk("R6 delay restarted, not yet released", sys_rst_n, 1'b0);
    ticks(1);
    chk("R6 released after full delay", sys_rst_n, 1'b1);

    // R4: short dip during the delay does not restart it
    lvl_above = 1'b0; cyc(F + 3); lvl_above = 1'b1; cyc(5);
    ticks(4);
    lvl_above = 1'b0; cyc(F - 1); lvl_above = 1'b1; cyc(5);
    ticks(TWD - 5);
    chk("R4 delay continues, one tick left", sys_rst_n, 1'b0);
    ticks(1);
    chk("R4 delay not restarted by short dip", sys_rst_n, 1'b1);

    // R8: asynchronous hardware reset while released
    @(posedge clk); #1 rst_n = 1'b0; #0.5;
    chk("R8 async reset forces output", sys_rst_n, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cyc(5);
    ticks(TWD - 1);
    chk("R8 full delay after hw reset", sys_rst_n, 1'b0);
    ticks(1);
    chk("R8 release after hw reset", sys_rst_n, 1'b1);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule